// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the word address for a four-beat burst into a synchronous memory. A start address is captured when either of two active-low address strobes is sampled low. After that, the two lowest address bits move through a four-step sequence, one step for each clock in which the active-low advance input is low. The higher address bits stay at the captured value for the whole burst.

A mode input chooses the beat order. Linear order counts upward modulo 4 from the start. Interleaved order XORs the start bits with the beat number. A clock enable freezes all state. The block drives only the address and the beat number. The storage array, the data path and the chip-select logic are outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is low and after its release with no stimulus, `addr_out` and `beat` are zero.
- R2: On a rising edge with `clk_en` high and either `strb_cpu_n` or `strb_ctl_n` low, `addr_in` is captured. From the next cycle `beat` is 0 and `addr_out` equals the captured address.
- R3: On a rising edge with `clk_en` high, both strobes high and `adv_n` low, `beat` increases by one modulo 4. The value 3 wraps to 0.
- R4: On a rising edge with `adv_n` high and both strobes high, `beat` and `addr_out` stay unchanged.
- R5: With `ilv_mode` = 1 (interleaved), `addr_out[1:0]` equals the captured low two bits XOR `beat`.
- R6: With `ilv_mode` = 0 (linear), `addr_out[1:0]` equals the captured low two bits plus `beat`, modulo 4.
- R7: `addr_out[AW-1:2]` changes only on a capture. Advancing never carries into these bits, and after the fourth beat a further advance returns the low bits to the start value.
- R8: When a strobe and `adv_n` are both low in the same enabled cycle, the capture wins. The new address is loaded and `beat` becomes 0.
- R9: On a rising edge with `clk_en` low, strobes and advance have no effect, and `beat` and `addr_out` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Clock enable; low holds all state |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ilv_mode | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | AW | Start address to capture |
| addr_out | output | AW | Current internal word address |
| beat | output | 2 | Beat number within the burst (0..3) |

## Verification
Each of the four low start values is walked through a full burst and one extra wrap step in both modes. This separates the XOR order from the add order: they differ only for start values 1 and 3. A start address with all upper bits set and low bits 3 shows that no carry leaks upward. Advance gaps, strobe-with-advance collisions, each strobe used alone, and enable-low cycles with active strobes show that the load and hold priorities are correct. The expected addresses come from the bench's own reference.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int LOW_W = 2;
  typedef logic [LOW_W-1:0] beat_t;

  // low-bit order for a given start and beat count
  function automatic beat_t bsq_order(input beat_t start, input beat_t cnt, input logic ilv);
    beat_t r;
    if (ilv) r = start ^ cnt;
    else     r = start + cnt;
    return r;
  endfunction
endpackage

// File: rtl/bsq_beat_ctr.sv
module bsq_beat_ctr
  import bsq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  load,
  input  logic  step,
  output beat_t cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (en) begin
      if (load)       cnt <= '0;
      else if (step)  cnt <= cnt + beat_t'(1);
    end
  end

  // R3 advance by one modulo 4
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(en && !load && step) |-> cnt == beat_t'($past(cnt) + beat_t'(1)));
  // R8 capture clears the count even with a step
  a_r8_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(en && load) |-> cnt == '0);
  // R9 and R4 hold
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!en || (!load && !step)) |-> $stable(cnt));
endmodule

// File: rtl/bsq_base_reg.sv
module bsq_base_reg #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)          q <= '0;
    else if (en && load) q <= d;
  end

  // R2 capture of the start address
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(en && load) |-> q == $past(d));
  // R9 no capture while disabled
  a_r9_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(!en) |-> $stable(q));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bsq_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          strb_cpu_n,
  input  logic          strb_ctl_n,
  input  logic          adv_n,
  input  logic          ilv_mode,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic [1:0]    beat
);
  localparam int UP_W = AW - LOW_W;

  // named events
  logic          load_evt;
  logic          step_evt;
  logic [AW-1:0] base_q;
  beat_t         cnt_q;
  beat_t         low_bits;

  assign load_evt = !strb_cpu_n || !strb_ctl_n;
  assign step_evt = !adv_n;

  bsq_base_reg #(.AW(AW)) u_base (
    .clk(clk), .rst_n(rst_n), .en(clk_en), .load(load_evt),
    .d(addr_in), .q(base_q)
  );

  bsq_beat_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .en(clk_en), .load(load_evt),
    .step(step_evt), .cnt(cnt_q)
  );

  assign low_bits = bsq_order(base_q[LOW_W-1:0], cnt_q, ilv_mode);
  assign addr_out = {base_q[AW-1:LOW_W], low_bits};
  assign beat     = cnt_q;

  // R7 upper bits move only on capture
  a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(clk_en && load_evt) |-> addr_out[AW-1:LOW_W] == $past(addr_out[AW-1:LOW_W]));
  // R2 first beat presents the captured address in either mode
  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(clk_en && load_evt) |-> addr_out == $past(addr_in));
  // R1 reset state
  a_r1_reset: assert property (@(posedge clk)
    $past(rst_n) == 1'b0 && $past(rst_n, 2) == 1'b0 && !rst_n |-> addr_out == '0 && beat == 2'd0);
  // R5 interleaved start bits recoverable from the output
  a_r5_xor: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ilv_mode && $past(ilv_mode) && !$past(clk_en && load_evt)
      && $past(clk_en && step_evt) |-> (addr_out[1:0] ^ beat) == ($past(addr_out[1:0]) ^ $past(beat)));

  logic unused_up;
  assign unused_up = ^UP_W;
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int AW = 17;
  logic clk = 1'b0;
  logic rst_n, clk_en, strb_cpu_n, strb_ctl_n, adv_n, ilv_mode;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic [1:0] beat;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  burst_addr_seq #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .strb_cpu_n(strb_cpu_n),
    .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .ilv_mode(ilv_mode),
    .addr_in(addr_in), .addr_out(addr_out), .beat(beat)
  );

  always #2 clk = ~clk;

  // independent reference: interleave by per-bit flip, linear by integer sum
  function automatic logic [1:0] ref_low(input logic [1:0] s, input int b, input logic ilv);
    int v;
    if (ilv) return {s[1] ^ b[1], s[0] ^ b[0]};
    v = (int'(s) + b) % 4;
    return v[1:0];
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    clk_en = 1; strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1;
  endtask

  task automatic t_reset();
    rst_n = 0; idle(); ilv_mode = 0; addr_in = '1;
    strb_cpu_n = 0;
    tick(); tick();
    chk("R1 addr", addr_out, '0);
    chk("R1 beat", AW'(beat), '0);
    rst_n = 1; idle();
    tick();
    chk("R1 after release", addr_out, '0);
  endtask

  task automatic t_sweep(input logic ilv, input logic [AW-1:2] up);
    for (int s = 0; s < 4; s++) begin
      logic [1:0] st = s[1:0];
      ilv_mode = ilv; idle();
      addr_in = {up, st};
      if (s % 2 == 0) strb_cpu_n = 0; else strb_ctl_n = 0;
      tick();
      chk("R2 capture", addr_out, {up, st});
      chk("R2 beat0", AW'(beat), '0);
      idle(); adv_n = 0;
      for (int b = 1; b <= 4; b++) begin
        tick();
        chk(ilv ? "R5 interleaved" : "R6 linear", addr_out, {up, ref_low(st, b % 4, ilv)});
        chk("R3 beat", AW'(beat), AW'(b % 4));
      end
      chk("R7 wrap to start", addr_out, {up, st});
      idle();
    end
  endtask

  task automatic t_hold_adv();
    idle(); ilv_mode = 0; addr_in = {15'h2A5A, 2'd1}; strb_cpu_n = 0;
    tick(); idle(); adv_n = 0; tick();
    idle(); tick(); tick();
    chk("R4 hold addr", addr_out, {15'h2A5A, 2'd2});
    chk("R4 hold beat", AW'(beat), AW'(1));
  endtask

  task automatic t_priority();
    idle(); ilv_mode = 1; addr_in = {15'h1111, 2'd2}; strb_ctl_n = 0;
    tick(); idle(); adv_n = 0; tick(); tick();
    adv_n = 0; strb_cpu_n = 0; addr_in = {15'h0F0F, 2'd3};
    tick();
    chk("R8 strobe wins addr", addr_out, {15'h0F0F, 2'd3});
    chk("R8 strobe wins beat", AW'(beat), '0);
    idle();
  endtask

  task automatic t_clk_en();
    idle(); ilv_mode = 0; addr_in = {15'h3333, 2'd0}; strb_cpu_n = 0;
    tick(); idle(); adv_n = 0; tick();
    clk_en = 0; strb_cpu_n = 0; strb_ctl_n = 0; adv_n = 0; addr_in = '1;
    tick(); tick();
    chk("R9 hold addr", addr_out, {15'h3333, 2'd1});
    chk("R9 hold beat", AW'(beat), AW'(1));
    idle(); adv_n = 0; tick();
    chk("R9 resume", addr_out, {15'h3333, 2'd2});
    idle();
  endtask

  initial begin
    t_reset();
    t_sweep(1'b0, 15'h1234);
    t_sweep(1'b1, 15'h0ACE);
    t_sweep(1'b0, '1);
    t_sweep(1'b1, '1);
    t_hold_adv();
    t_priority();
    t_clk_en();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule